// File: doc/BRIEF.md
# Reverse Rotation Protection Monitor

This block watches the three Hall sensor bits of a three-phase brushless motor and decides whether the rotor is turning in the commanded direction. Each valid Hall code is turned into one of six rotor positions. Each change of position is then classed as a step with the command, a step against it, or neither. A run of backward steps of more than 120 electrical degrees, that is at least three steps with no forward step between them, marks the rotor as reversing.

Reversing alone does not stop the motor. While the motor is driven and reversing, a grace timer counts reference ticks. When it reaches the lock timeout, a fault is latched. The fault asks for all six power outputs to be switched off. The same timer covers two cases: a reversal that starts during drive, and a rotor that is already turning backwards when drive begins. While the monitor is enabled, zero output duty also asks for all outputs off. The fault is cleared by a stop command held for a minimum number of cycles, by zero duty held over a set number of reference ticks, or by reset. When the active-low enable is high, the monitor requests nothing and holds no fault.

Top module: `rev_rotation_guard`

## Requirements
- R1: While `guard_n` is high, `all_off` is 0 whatever the other inputs are. Any latched fault is dropped, so after `guard_n` returns low, `all_off` stays 0 until a new full timeout has run.
- R2: While `guard_n` is low and `duty_zero` is high, `all_off` is 1 in the same cycle.
- R3: With `dir_sel` = 0, forward is the Hall code order 101, 100, 110, 010, 011, 001 (and round again). With `dir_sel` = 1, forward is the opposite order. Forward rotation never latches a fault, and any forward step clears the backward count.
- R4: The rotor counts as reversing only after three backward steps in a row. Two backward steps, then a forward step, then two more backward steps do not count as reversing.
- R5: Hall codes 000 and 111 are ignored. They do not move the tracked position, do not add a step and do not clear the backward count.
- R6: While `guard_n` is low, `drive_on` is high, `stop_req` and `duty_zero` are low and the rotor is reversing, the fault latches at the clock edge that samples the LOCK_TICKS-th `ref_tick` pulse. No fault is latched before that edge.
- R7: A rotor that is already reversing before `drive_on` rises gets the same full grace period, counted from the moment drive starts.
- R8: Once latched, the fault keeps `all_off` at 1 even after forward rotation resumes.
- R9: `stop_req` held high for STOP_HOLD consecutive cycles clears the fault. A shorter hold does not clear it.
- R10: `duty_zero` held high across CLR_TICKS `ref_tick` pulses clears the fault. A shorter hold does not clear it.
- R11: After reset, `all_off` is 0 while `duty_zero` is low.
- R12: If reversing stops before the timeout (because of a forward step), the grace count starts again from zero at the next reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall | input | 3 | Hall sensor bits, phase 1 in bit 2, phase 3 in bit 0 |
| dir_sel | input | 1 | Commanded direction, 0 or 1 as defined in R3 |
| guard_n | input | 1 | Monitor enable, active low |
| drive_on | input | 1 | Motor is being driven |
| duty_zero | input | 1 | Output duty is zero |
| stop_req | input | 1 | Stop command |
| ref_tick | input | 1 | One-cycle reference pulse that paces the lock timeout and the duty-zero clear |
| all_off | output | 1 | Request to switch all six outputs off |

## Verification
The hardest state to reach from the ports is a reversal that is real and already counted, but whose grace count is cut short. Only the moment of the fault shows whether the count really restarted. To get there, the stimulus first builds a full backward run and lets the timer come within one tick of the limit. It then inserts a single forward step, builds a new backward run, and checks that the fault waits a full timeout again. A sweep over both directions, every start position and zero to four backward steps checks the three-step threshold. Invalid codes placed between backward steps confirm that they neither break the run nor extend it.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

  typedef struct packed {
    logic       ok;
    logic [2:0] pos;
  } hall_pos_t;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_FWD  = 2'd1,
    MV_BWD  = 2'd2
  } move_t;

  // map a Hall code to a rotor position 0..5; 000 and 111 are invalid
  function automatic hall_pos_t code_to_pos(input logic [2:0] h);
    hall_pos_t r;
    r.ok  = 1'b1;
    r.pos = 3'd0;
    case (h)
      3'b101: r.pos = 3'd0;
      3'b100: r.pos = 3'd1;
      3'b110: r.pos = 3'd2;
      3'b010: r.pos = 3'd3;
      3'b011: r.pos = 3'd4;
      3'b001: r.pos = 3'd5;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  // (b - a) modulo 6
  function automatic logic [2:0] pos_diff(input logic [2:0] a, input logic [2:0] b);
    logic [3:0] t;
    t = {1'b0, b} + 4'd6 - {1'b0, a};
    if (t >= 4'd6) t = t - 4'd6;
    return t[2:0];
  endfunction

  // class a one-position move against the commanded direction
  function automatic move_t classify(input logic [2:0] d, input logic dir);
    move_t m;
    m = MV_NONE;
    if (d == 3'd1)      m = dir ? MV_BWD : MV_FWD;
    else if (d == 3'd5) m = dir ? MV_FWD : MV_BWD;
    return m;
  endfunction

endpackage

// File: rtl/rrp_step_tracker.sv
module rrp_step_tracker
  import rrp_pkg::*;
#(
  parameter int REV_STEPS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall,
  input  logic       dir_sel,
  output logic [2:0] pos,
  output logic       fwd_step,
  output logic       bwd_step,
  output logic       reversing
);

  localparam int AW = $clog2(REV_STEPS + 1);

  hall_pos_t cur;
  move_t     mv;
  logic      have_prev;
  logic [AW-1:0] back_cnt;

  always_comb begin
    cur      = code_to_pos(hall);
    mv       = classify(pos_diff(pos, cur.pos), dir_sel);
    fwd_step = cur.ok && have_prev && (mv == MV_FWD);
    bwd_step = cur.ok && have_prev && (mv == MV_BWD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= 3'd0;
      have_prev <= 1'b0;
      back_cnt  <= '0;
    end else begin
      if (cur.ok) begin
        pos       <= cur.pos;
        have_prev <= 1'b1;
      end
      if (fwd_step)
        back_cnt <= '0;
      else if (bwd_step && (back_cnt < AW'(REV_STEPS)))
        back_cnt <= back_cnt + 1'b1;
    end
  end

  assign reversing = (back_cnt >= AW'(REV_STEPS));

endmodule

// File: rtl/rrp_grace_timer.sv
module rrp_grace_timer #(
  parameter int LOCK_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic trip
);

  localparam int CW = $clog2(LOCK_TICKS + 1);

  logic [CW-1:0] cnt;

  assign trip = arm && tick && (cnt == CW'(LOCK_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!arm)    cnt <= '0;
    else if (trip)    cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rrp_fault_latch.sv
module rrp_fault_latch #(
  parameter int STOP_HOLD = 4,
  parameter int CLR_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trip,
  input  logic stop_req,
  input  logic duty_zero,
  input  logic tick,
  output logic fault,
  output logic clear_evt
);

  localparam int SW = $clog2(STOP_HOLD + 1);
  localparam int ZW = $clog2(CLR_TICKS + 1);

  logic [SW-1:0] stop_cnt;
  logic [ZW-1:0] zero_cnt;
  logic          stop_clr;
  logic          zero_clr;

  assign stop_clr  = stop_req && (stop_cnt == SW'(STOP_HOLD - 1));
  assign zero_clr  = duty_zero && tick && (zero_cnt == ZW'(CLR_TICKS - 1));
  assign clear_evt = stop_clr || zero_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_cnt <= '0;
      zero_cnt <= '0;
      fault    <= 1'b0;
    end else begin
      if (!stop_req)                             stop_cnt <= '0;
      else if (stop_cnt < SW'(STOP_HOLD - 1))    stop_cnt <= stop_cnt + 1'b1;

      if (!duty_zero)                                 zero_cnt <= '0;
      else if (tick && (zero_cnt < ZW'(CLR_TICKS - 1))) zero_cnt <= zero_cnt + 1'b1;

      if (!en)            fault <= 1'b0;
      else if (clear_evt) fault <= 1'b0;
      else if (trip)      fault <= 1'b1;
    end
  end

endmodule

// File: rtl/rev_rotation_guard.sv
module rev_rotation_guard #(
  parameter int REV_STEPS  = 3,
  parameter int LOCK_TICKS = 8,
  parameter int STOP_HOLD  = 4,
  parameter int CLR_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall,
  input  logic       dir_sel,
  input  logic       guard_n,
  input  logic       drive_on,
  input  logic       duty_zero,
  input  logic       stop_req,
  input  logic       ref_tick,
  output logic       all_off
);

  logic       en_w;
  logic [2:0] pos_w;
  logic       fwd_w;
  logic       bwd_w;
  logic       rev_w;
  logic       arm_w;
  logic       trip_w;
  logic       fault_w;
  logic       clear_w;

  assign en_w = !guard_n;

  rrp_step_tracker #(.REV_STEPS(REV_STEPS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall      (hall),
    .dir_sel   (dir_sel),
    .pos       (pos_w),
    .fwd_step  (fwd_w),
    .bwd_step  (bwd_w),
    .reversing (rev_w)
  );

  assign arm_w = en_w && drive_on && !stop_req && !duty_zero && rev_w && !fault_w;

  rrp_grace_timer #(.LOCK_TICKS(LOCK_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm_w),
    .tick  (ref_tick),
    .trip  (trip_w)
  );

  rrp_fault_latch #(.STOP_HOLD(STOP_HOLD), .CLR_TICKS(CLR_TICKS)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_w),
    .trip      (trip_w),
    .stop_req  (stop_req),
    .duty_zero (duty_zero),
    .tick      (ref_tick),
    .fault     (fault_w),
    .clear_evt (clear_w)
  );

  assign all_off = en_w && (fault_w || duty_zero);

endmodule

// File: rtl/rev_rotation_guard_chk.sv
module rev_rotation_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall,
  input logic       guard_n,
  input logic       duty_zero,
  input logic       all_off,
  input logic [2:0] pos_w,
  input logic       fwd_w,
  input logic       bwd_w,
  input logic       rev_w,
  input logic       trip_w,
  input logic       fault_w,
  input logic       clear_w
);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guard_n |-> !all_off);

  // R2
  zero_duty_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_n && duty_zero) |-> all_off);

  // R3
  fwd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_w |=> !rev_w);

  // R4
  rev_needs_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_w) |-> $past(bwd_w));

  // R5
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hall == 3'b000 || hall == 3'b111) |=> $stable(pos_w));

  // R6
  trip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_w) |-> $past(trip_w));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_w && !guard_n && !clear_w) |=> fault_w);

endmodule

bind rev_rotation_guard rev_rotation_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hall      (hall),
  .guard_n   (guard_n),
  .duty_zero (duty_zero),
  .all_off   (all_off),
  .pos_w     (pos_w),
  .fwd_w     (fwd_w),
  .bwd_w     (bwd_w),
  .rev_w     (rev_w),
  .trip_w    (trip_w),
  .fault_w   (fault_w),
  .clear_w   (clear_w)
);

// File: tb/tb_rev_rotation_guard.sv
module tb_rev_rotation_guard;

  localparam int LOCK = 8;
  localparam int HOLD = 4;
  localparam int CLRT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b101;
  logic       dir_sel = 1'b0;
  logic       guard_n = 1'b0;
  logic       drive_on = 1'b0;
  logic       duty_zero = 1'b0;
  logic       stop_req = 1'b0;
  logic       ref_tick = 1'b0;
  logic       all_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int p      = 0;

  always #4 clk = ~clk;

  rev_rotation_guard #(.REV_STEPS(3), .LOCK_TICKS(LOCK), .STOP_HOLD(HOLD), .CLR_TICKS(CLRT)) dut (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_sel(dir_sel), .guard_n(guard_n),
    .drive_on(drive_on), .duty_zero(duty_zero), .stop_req(stop_req),
    .ref_tick(ref_tick), .all_off(all_off)
  );

  function automatic logic [2:0] code_of(input int i);
    logic [2:0] seq [6];
    seq = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    return seq[i];
  endfunction

  function automatic int ahead(input int i, input bit d);
    return d ? (i + 5) % 6 : (i + 1) % 6;
  endfunction

  function automatic int behind(input int i, input bit d);
    return d ? (i + 1) % 6 : (i + 5) % 6;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: all_off=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic go_fwd(input int n);
    for (int k = 0; k < n; k++) begin
      p = ahead(p, dir_sel); hall = code_of(p); @(negedge clk);
    end
  endtask

  task automatic go_back(input int n);
    for (int k = 0; k < n; k++) begin
      p = behind(p, dir_sel); hall = code_of(p); @(negedge clk);
    end
  endtask

  task automatic restart(input bit d, input int start);
    rst_n = 1'b0; guard_n = 1'b0; drive_on = 1'b1; duty_zero = 1'b0;
    stop_req = 1'b0; ref_tick = 1'b0; dir_sel = d;
    p = start; hall = code_of(p);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: all_off=%0d expected run to finish", all_off);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    restart(1'b0, 0);
    chk("R11", all_off, 0);

    // R3 R4 sweep: both directions, all starts, 0..4 backward steps
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 6; s++)
        for (int nb = 0; nb < 5; nb++) begin
          restart(d[0], s);
          go_fwd(2);
          go_back(nb);
          ticks(LOCK - 1);
          chk("R3/R6 early", all_off, 0);
          ticks(1);
          chk("R4 threshold", all_off, (nb >= 3) ? 1 : 0);
        end

    // R4 interrupted run
    restart(1'b0, 2);
    go_back(2); go_fwd(1); go_back(2);
    ticks(LOCK + 1);
    chk("R4 broken run", all_off, 0);
    go_back(1);
    ticks(LOCK);
    chk("R4 third step", all_off, 1);

    // R5 invalid codes neither count nor break
    restart(1'b1, 3);
    go_back(2);
    hall = 3'b000; @(negedge clk);
    hall = 3'b111; @(negedge clk);
    ticks(LOCK + 1);
    chk("R5 no count", all_off, 0);
    hall = 3'b111; @(negedge clk);
    go_back(1);
    ticks(LOCK);
    chk("R5 no break", all_off, 1);

    // R7 reversing before drive
    restart(1'b0, 4);
    drive_on = 1'b0;
    @(negedge clk);
    go_back(3);
    ticks(LOCK + 2);
    chk("R7 idle", all_off, 0);
    drive_on = 1'b1;
    ticks(LOCK - 1);
    chk("R7 grace", all_off, 0);
    ticks(1);
    chk("R7 trip", all_off, 1);

    // R8 latched after forward resumes
    go_fwd(3);
    chk("R8", all_off, 1);

    // R9 stop clear
    stop_req = 1'b1; repeat (HOLD - 1) @(negedge clk);
    stop_req = 1'b0; @(negedge clk);
    chk("R9 short stop", all_off, 1);
    stop_req = 1'b1; repeat (HOLD) @(negedge clk);
    stop_req = 1'b0; @(negedge clk);
    chk("R9 stop clears", all_off, 0);

    // R10 zero-duty clear
    go_back(3);
    ticks(LOCK);
    chk("R10 setup", all_off, 1);
    duty_zero = 1'b1; #1;
    chk("R2", all_off, 1);
    ticks(CLRT - 1);
    duty_zero = 1'b0; @(negedge clk);
    chk("R10 short hold", all_off, 1);
    duty_zero = 1'b1;
    ticks(CLRT);
    duty_zero = 1'b0; @(negedge clk);
    chk("R10 clears", all_off, 0);

    // R12 restart of grace count
    restart(1'b1, 1);
    go_back(3);
    ticks(LOCK - 1);
    go_fwd(1);
    go_back(3);
    ticks(LOCK - 1);
    chk("R12 restarted", all_off, 0);
    ticks(1);
    chk("R12 trip", all_off, 1);

    // R1 disabled
    guard_n = 1'b1; #1;
    chk("R1 fault hidden", all_off, 0);
    duty_zero = 1'b1; #1;
    chk("R1 zero duty", all_off, 0);
    duty_zero = 1'b0;
    ticks(LOCK + 1);
    chk("R1 no trip", all_off, 0);
    guard_n = 1'b0; @(negedge clk);
    chk("R1 fault dropped", all_off, 0);
    ticks(LOCK - 1);
    chk("R6 early", all_off, 0);
    ticks(1);
    chk("R6 trip", all_off, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule